// File: doc/BRIEF.md
# Eight-LED Table-Tennis Game Controller

This block runs a two-player table-tennis game on a row of eight LEDs. One lit LED stands for the ball, and it advances one place every game tick. The tick is made by dividing the system clock, so the divider parameter sets how fast the ball moves. Player A defends the low end of the row and player B defends the high end.

A player returns the ball by pressing a button while the ball sits on that player's last LED. A ball that runs past an end without a return gives one point to the other player. The ball then stays off the table until the referee presses the pick-up strobe. The strobe puts the ball on the end LED of whichever player holds the serve. That player's press launches it, and the serve passes to the other player every two points. When either score reaches the winning count the game is over. A referee clear input starts a new game.

Top module: `pong_line_ctrl`

## Requirements
- R1: `ball_led[k]` is lit alone while the ball is at table position k+1 (positions 1 to 8). Bit 0 is A's end and bit 7 is B's end. While the ball is off the table (position 0 past A, position 9 past B), `ball_led` is all zero.
- R2: A ball in play moves exactly one position every TICK_DIV clock cycles, keeping its current direction.
- R3: A press by A counts only while bit 0 is lit, and it sends the ball toward bit 7. A press by B counts only while bit 7 is lit, and it sends the ball toward bit 0. Presses at any other position have no effect on the ball.
- R4: A ball that steps past bit 0 gives one point to B. A ball that steps past bit 7 gives one point to A. In both cases the ball stays off the table afterwards.
- R5: Each point raises the scorer's binary score by exactly one and leaves the other score unchanged.
- R6: `game_over` goes high once either score equals WIN_SCORE (default 11). After that, scores no longer change and the pick-up strobe is ignored until clear.
- R7: A holds the serve after reset (`serve_a`=1, `serve_b`=0). The serve passes to the other player after every SERVE_SWAP (default 2) points.
- R8: When the ball is not in play and the game is not over, the pick-up strobe places the ball on bit 0 if A serves or on bit 7 if B serves. The ball then waits there, and only the server's press launches it. A pick-up during a rally is ignored.
- R9: Clear sets both scores to zero, lowers `game_over`, gives the serve to A and takes the ball off the table.
- R10: After reset, `ball_led` is zero, both scores are zero, `game_over` is low and A holds the serve.
- R11: Each button is synchronised and edge-detected, so one press gives exactly one hit event. Presses while the ball is off the table change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hit_a | input | 1 | Player A button (asynchronous) |
| hit_b | input | 1 | Player B button (asynchronous) |
| pickup | input | 1 | Referee strobe that places the ball for the serve |
| clear | input | 1 | Referee new-game clear |
| ball_led | output | NUM_LED | One-hot ball position |
| serve_a | output | 1 | A holds the serve |
| serve_b | output | 1 | B holds the serve |
| score_a | output | SW | Points of player A, binary |
| score_b | output | SW | Points of player B, binary |
| game_over | output | 1 | A score has reached WIN_SCORE |

## Verification
The hardest situation to reach is a returned rally. The return press has to land inside the TICK_DIV-cycle window while the ball rests on an end LED, even though the synchroniser delays it by several cycles. The stimulus polls `ball_led` every cycle and presses as soon as the end LED lights. It then plays a full game of scripted points, mixing aces and returns, until a score reaches WIN_SCORE. This walks the serve rotation through several swaps and reaches the end-of-game freeze.

// File: rtl/pong_line_ctrl.sv
module pong_line_ctrl #(
  parameter int TICK_DIV   = 5_000_000,
  parameter int NUM_LED    = 8,
  parameter int WIN_SCORE  = 11,
  parameter int SERVE_SWAP = 2,
  localparam int SW = $clog2(WIN_SCORE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_a,
  input  logic               hit_b,
  input  logic               pickup,
  input  logic               clear,
  output logic [NUM_LED-1:0] ball_led,
  output logic               serve_a,
  output logic               serve_b,
  output logic [SW-1:0]      score_a,
  output logic [SW-1:0]      score_b,
  output logic               game_over
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PW = $clog2(NUM_LED + 2);
  localparam int CW = (SERVE_SWAP > 1) ? $clog2(SERVE_SWAP) : 1;
  localparam logic [PW-1:0] OFF_A = '0;
  localparam logic [PW-1:0] END_A = PW'(1);
  localparam logic [PW-1:0] END_B = PW'(NUM_LED);
  localparam logic [PW-1:0] OFF_B = PW'(NUM_LED + 1);
  localparam logic [SW-1:0] WIN   = SW'(WIN_SCORE);

  logic [TW-1:0] tick_cnt;
  logic [2:0]    sync_a, sync_b;
  logic [PW-1:0] pos;
  logic          up, live, ready, srv_b;
  logic [CW-1:0] srv_cnt;

  wire tick     = (tick_cnt == TW'(TICK_DIV - 1));
  wire ev_a     = sync_a[1] & ~sync_a[2];
  wire ev_b     = sync_b[1] & ~sync_b[2];
  wire a_ok     = ev_a && pos == END_A && (live || ready);
  wire b_ok     = ev_b && pos == END_B && (live || ready);
  wire up_n     = a_ok ? 1'b1 : (b_ok ? 1'b0 : up);
  wire moving   = live || a_ok || b_ok;
  wire [PW-1:0] step = up_n ? pos + 1'b1 : pos - 1'b1;
  wire advance  = moving && tick;
  wire lost_a   = advance && step == OFF_A;
  wire lost_b   = advance && step == OFF_B;
  wire point    = lost_a || lost_b;

  assign game_over = (score_a == WIN) || (score_b == WIN);
  assign serve_b   = srv_b;
  assign serve_a   = ~srv_b;

  for (genvar i = 0; i < NUM_LED; i++) begin : g_led
    assign ball_led[i] = (pos == PW'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      sync_a   <= '0;
      sync_b   <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      sync_a   <= {sync_a[1:0], hit_a};
      sync_b   <= {sync_b[1:0], hit_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= OFF_A;
      up      <= 1'b0;
      live    <= 1'b0;
      ready   <= 1'b0;
      srv_b   <= 1'b0;
      srv_cnt <= '0;
      score_a <= '0;
      score_b <= '0;
    end else if (clear) begin
      pos     <= OFF_A;
      up      <= 1'b0;
      live    <= 1'b0;
      ready   <= 1'b0;
      srv_b   <= 1'b0;
      srv_cnt <= '0;
      score_a <= '0;
      score_b <= '0;
    end else begin
      up <= up_n;
      if (pickup && !live && !game_over) begin
        pos   <= srv_b ? END_B : END_A;
        up    <= ~srv_b;
        ready <= 1'b1;
      end else begin
        if (a_ok || b_ok) begin
          live  <= 1'b1;
          ready <= 1'b0;
        end
        if (advance) begin
          pos <= step;
          if (point) live <= 1'b0;
        end
      end
      if (point && !game_over) begin
        if (lost_a) score_b <= score_b + 1'b1;
        if (lost_b) score_a <= score_a + 1'b1;
        if (srv_cnt == CW'(SERVE_SWAP - 1)) begin
          srv_cnt <= '0;
          srv_b   <= ~srv_b;
        end else begin
          srv_cnt <= srv_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pong_line_chk.sv
module pong_line_chk #(
  parameter int NUM_LED   = 8,
  parameter int WIN_SCORE = 11,
  localparam int SW = $clog2(WIN_SCORE + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pickup,
  input logic               clear,
  input logic [NUM_LED-1:0] ball_led,
  input logic               serve_a,
  input logic [SW-1:0]      score_a,
  input logic [SW-1:0]      score_b,
  input logic               game_over
);
  AST_BALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ball_led != '0 && !pickup) |=> (ball_led == '0 || ball_led == $past(ball_led) ||
      ball_led == ($past(ball_led) << 1) || ball_led == ($past(ball_led) >> 1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    score_a <= SW'(WIN_SCORE) && score_b <= SW'(WIN_SCORE)); // R6
  AST_SCORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((score_a == $past(score_a) && (score_b == $past(score_b) || score_b == $past(score_b) + SW'(1)))
             || (score_b == $past(score_b) && score_a == $past(score_a) + SW'(1)))); // R5
  AST_OVER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (game_over && !clear) |=> ($stable(score_a) && $stable(score_b))); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (score_a == '0 && score_b == '0 && !game_over && serve_a && ball_led == '0)); // R9
  AST_SERVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ($stable(serve_a) || score_a != $past(score_a) || score_b != $past(score_b))); // R7
endmodule

bind pong_line_ctrl pong_line_chk #(.NUM_LED(NUM_LED), .WIN_SCORE(WIN_SCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pickup(pickup), .clear(clear), .ball_led(ball_led),
  .serve_a(serve_a), .score_a(score_a), .score_b(score_b), .game_over(game_over));

// File: tb/pong_line_ctrl_tb.sv
module pong_line_ctrl_tb;
  localparam int TD = 16;
  localparam int WIN = 11;
  localparam int SWAP = 2;
  localparam int SW = $clog2(WIN + 1);

  logic clk = 1'b0, rst_n = 1'b0, hit_a = 1'b0, hit_b = 1'b0, pickup = 1'b0, clear = 1'b0;
  logic [7:0] ball_led;
  logic serve_a, serve_b, game_over;
  logic [SW-1:0] score_a, score_b;

  pong_line_ctrl #(.TICK_DIV(TD), .NUM_LED(8), .WIN_SCORE(WIN), .SERVE_SWAP(SWAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b), .pickup(pickup), .clear(clear),
    .ball_led(ball_led), .serve_a(serve_a), .serve_b(serve_b),
    .score_a(score_a), .score_b(score_b), .game_over(game_over));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int exp_a = 0, exp_b = 0, pts = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_pick();
    @(negedge clk) pickup = 1'b1;
    @(negedge clk) pickup = 1'b0;
  endtask

  task automatic press(input bit is_b);
    @(negedge clk);
    if (is_b) hit_b = 1'b1; else hit_a = 1'b1;
    idle(4);
    hit_a = 1'b0;
    hit_b = 1'b0;
  endtask

  task automatic wait_led(input logic [7:0] pat, input string req, output int t);
    int n;
    n = 0;
    while (ball_led !== pat && n < 40 * TD) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
    if (ball_led !== pat) chk(1'b0, req, ball_led, pat);
  endtask

  task automatic travel(input bit go_up, input string req);
    int t, prev;
    prev = 0;
    for (int i = 1; i < 8; i++) begin
      wait_led(go_up ? 8'(1 << i) : 8'(1 << (7 - i)), req, t);
      if (i > 1) chk(t - prev == TD, "R2 step interval", t - prev, TD);
      prev = t;
    end
  endtask

  task automatic check_tally();
    chk(score_a == SW'(exp_a), "R5 score_a", score_a, exp_a);
    chk(score_b == SW'(exp_b), "R5 score_b", score_b, exp_b);
    chk(serve_b == bit'((pts / SWAP) % 2), "R7 serve owner", serve_b, (pts / SWAP) % 2);
    chk(game_over == (exp_a == WIN || exp_b == WIN), "R6 game_over", game_over, exp_a == WIN || exp_b == WIN);
  endtask

  task automatic play_point(input bit srv_is_b, input bit srv_wins);
    int t;
    strobe_pick();
    idle(1);
    chk(ball_led == (srv_is_b ? 8'h80 : 8'h01), "R8 pick-up at server end", ball_led, srv_is_b ? 8'h80 : 8'h01);
    press(srv_is_b);
    travel(!srv_is_b, "R3 serve travel");
    if (!srv_wins) begin
      press(!srv_is_b);
      travel(srv_is_b, "R3 return travel");
    end
    wait_led(8'h00, "R4 ball leaves table", t);
    idle(1);
    pts++;
    if (srv_wins == srv_is_b) exp_b++; else exp_a++;
    check_tally();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int t;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(ball_led == 8'h00, "R10 ball off", ball_led, 0);
    chk(score_a == 0 && score_b == 0, "R10 scores", score_a + score_b, 0);
    chk(serve_a == 1'b1 && serve_b == 1'b0, "R10 serve A", serve_a, 1);
    chk(game_over == 1'b0, "R10 game_over", game_over, 0);

    press(1'b0);
    press(1'b1);
    idle(3 * TD);
    chk(ball_led == 8'h00, "R11 presses off table ignored", ball_led, 0);
    chk(score_a == 0 && score_b == 0, "R11 scores untouched", score_a + score_b, 0);

    strobe_pick();
    idle(1);
    chk(ball_led == 8'h01, "R8 pick-up on A end", ball_led, 8'h01);
    press(1'b1);
    idle(3 * TD);
    chk(ball_led == 8'h01, "R8 non-server press ignored", ball_led, 8'h01);

    press(1'b0);
    wait_led(8'h08, "R1 ball reaches bit 3", t);
    press(1'b0);
    strobe_pick();
    idle(1);
    chk(ball_led == 8'h08 || ball_led == 8'h10, "R8 pick-up during rally ignored", ball_led, 8'h08);
    wait_led(8'h80, "R3 mid-table press ignored", t);
    press(1'b1);
    travel(1'b0, "R3 B return");
    wait_led(8'h00, "R4 miss past A", t);
    idle(1);
    pts = 1;
    exp_b = 1;
    check_tally();
    idle(3 * TD);
    chk(ball_led == 8'h00, "R4 ball stays off", ball_led, 0);

    for (int p = 1; p < 40 && exp_a < WIN && exp_b < WIN; p++)
      play_point(bit'((pts / SWAP) % 2), (p % 3) != 1);

    chk(game_over == 1'b1, "R6 game ended", game_over, 1);
    strobe_pick();
    idle(2 * TD);
    chk(ball_led == 8'h00, "R6 pick-up ignored after game", ball_led, 0);
    check_tally();

    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    chk(score_a == 0 && score_b == 0, "R9 scores cleared", score_a + score_b, 0);
    chk(game_over == 1'b0, "R9 game_over low", game_over, 0);
    chk(serve_a == 1'b1, "R9 serve to A", serve_a, 1);
    strobe_pick();
    idle(1);
    chk(ball_led == 8'h01, "R9 new game serve from A", ball_led, 8'h01);

    summary();
  end
endmodule